// File: doc/BRIEF.md
# Event-Toggle Status Notifier

This block keeps one status word that tells software about per-channel events without asking software to acknowledge anything. Completion and error events flip bits inside a small slot owned by the reporting channel. Because the bits flip, every transition is visible to software as a change. Hardware-fault indications (bad wakeups, and a bad seal on the schedule table) set sticky bits instead, so at least one occurrence always survives.

Once per line period an end-of-period strobe makes the block compare the status word with the copy it last wrote out. If the two differ, the block offers the new word on a valid/ready write stream. When that write is accepted, the block records it as the last-written copy and ORs an interrupt mask into a pending-interrupt word. It also pulses a reschedule request for one cycle.

The write stream follows the usual back-pressure rules. Once `wr_valid` is high, it and `wr_data` hold steady until a cycle with `wr_ready` high. A strobe that arrives while a write is outstanding is dropped, because the next period's compare still sees any difference. Event inputs have no ready: they are always taken in the cycle they are valid.

Top module: `evt_toggle_notifier`

## Requirements
- R1: Reset leaves the status word, the last-written copy, `wr_valid`, `irq_pending` and `resched` all zero.
- R2: A completion event on channel c toggles status bit 3c (completion prototype 3'b001 shifted left by 3c).
- R3: An error event on channel c toggles status bit 3c+1 (prototype 3'b010 shifted left by 3c). Two events of the same kind on the same channel cancel. Bit 3c+2 stays zero.
- R4: A bad-wakeup on channel c sets status bit 12+c. No event clears it.
- R5: A bad table seal sets status bit 16. No event clears it.
- R6: With no write outstanding, a strobe compares the status word with the last-written copy. Events in the strobe cycle are applied before the compare. If the two differ, `wr_valid` is high in the next cycle and `wr_data` holds the updated word. If they are equal, no write starts.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid` and `wr_data` hold steady. A strobe in that state has no effect.
- R8: On an accepted write (`wr_valid` and `wr_ready` both high), the last-written copy takes `wr_data`, `irq_pending` ORs in `int_mask` as sampled in that cycle, and `resched` is high for exactly the next cycle. `irq_pending` bits never clear.
- R9: Events during an outstanding write update the status word but not `wr_data`. They are reported by a later period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_valid | input | 1 | Completion event strobe |
| done_ch | input | 2 | Channel of the completion event |
| err_valid | input | 1 | Error event strobe |
| err_ch | input | 2 | Channel of the error event |
| wake_valid | input | 1 | Bad-wakeup strobe |
| wake_ch | input | 2 | Channel of the bad wakeup |
| seal_bad | input | 1 | Schedule table seal check failed |
| period_end | input | 1 | End-of-line-period strobe |
| int_mask | input | 16 | Bits to OR into the pending word on notify |
| wr_valid | output | 1 | Status write offered |
| wr_ready | input | 1 | Status write accepted |
| wr_data | output | 17 | Status word being written |
| irq_pending | output | 16 | Accumulated pending-interrupt word |
| resched | output | 1 | One-cycle reschedule request |

## Verification
Each result has a fixed delay. An event or strobe sampled at a rising edge shows in `wr_valid` and `wr_data` one cycle later. An accepted write shows in `irq_pending` and `resched` one cycle after the accepting edge. A behavioural model in the bench advances on every rising edge from the same inputs, and every output is compared against it at the following falling edge. Because both sides update on the same edge and are compared half a cycle later, each check samples exactly in the cycle its result is due. Directed sequences then read the status back through the write stream to check slot positions, cancellation, sticky bits, same-cycle ordering and the dropped strobe under back-pressure.

// File: rtl/ntf_pkg.sv
package ntf_pkg;
  // Width of one channel's toggle slot and the event prototypes placed in it
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] PROTO_DONE = 3'b001;
  localparam logic [SLOT_W-1:0] PROTO_ERR  = 3'b010;

  // Status word width for a given channel count
  function automatic int stat_width(input int nch);
    return nch * SLOT_W + nch + 1;
  endfunction
endpackage

// File: rtl/ntf_status_reg.sv
module ntf_status_reg
  import ntf_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int TOG_W  = NUM_CH * SLOT_W,
  localparam int STAT_W = TOG_W + NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_valid,
  input  logic [CHW-1:0]    done_ch,
  input  logic              err_valid,
  input  logic [CHW-1:0]    err_ch,
  input  logic              wake_valid,
  input  logic [CHW-1:0]    wake_ch,
  input  logic              seal_bad,
  output logic [STAT_W-1:0] status_d,
  output logic [STAT_W-1:0] status_q
);
  logic [TOG_W-1:0]  tog_mask;
  logic [NUM_CH-1:0] wake_set;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    logic hit_done, hit_err;
    assign hit_done = done_valid && (done_ch == CHW'(c));
    assign hit_err  = err_valid  && (err_ch  == CHW'(c));
    assign tog_mask[c*SLOT_W +: SLOT_W] =
        ({SLOT_W{hit_done}} & PROTO_DONE) ^ ({SLOT_W{hit_err}} & PROTO_ERR);
    assign wake_set[c] = wake_valid && (wake_ch == CHW'(c));
  end

  always_comb begin
    status_d = status_q ^ {{(NUM_CH + 1){1'b0}}, tog_mask};
    status_d = status_d | {seal_bad, wake_set, {TOG_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  // R4 R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q[STAT_W-1:TOG_W] & $past(status_q[STAT_W-1:TOG_W]))
              == $past(status_q[STAT_W-1:TOG_W])));

  // R2 R3
  toggle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_valid || err_valid) |=> $stable(status_q[TOG_W-1:0]));
endmodule

// File: rtl/ntf_change_detect.sv
module ntf_change_detect #(
  parameter int STAT_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status_d,
  input  logic              period_end,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [STAT_W-1:0] wr_data,
  output logic              wr_fire
);
  logic [STAT_W-1:0] last_q;
  logic              start;

  assign wr_fire = wr_valid && wr_ready;
  assign start   = period_end && !wr_valid && (status_d != last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      if (wr_fire) begin
        last_q   <= wr_data;
        wr_valid <= 1'b0;
      end
      if (start) begin
        wr_valid <= 1'b1;
        wr_data  <= status_d;
      end
    end
  end

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R6
  wr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid && !period_end |=> !wr_valid);
endmodule

// File: rtl/ntf_irq_merge.sv
module ntf_irq_merge #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic [IRQ_W-1:0] int_mask,
  output logic [IRQ_W-1:0] irq_pending,
  output logic             resched
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pending <= '0;
      resched     <= 1'b0;
    end else begin
      resched <= wr_fire;
      if (wr_fire) irq_pending <= irq_pending | int_mask;
    end
  end

  // R8
  resched_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> resched);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_pending & $past(irq_pending)) == $past(irq_pending)));
endmodule

// File: rtl/evt_toggle_notifier.sv
module evt_toggle_notifier
  import ntf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_W  = 16,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int STAT_W = NUM_CH * SLOT_W + NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_valid,
  input  logic [CHW-1:0]    done_ch,
  input  logic              err_valid,
  input  logic [CHW-1:0]    err_ch,
  input  logic              wake_valid,
  input  logic [CHW-1:0]    wake_ch,
  input  logic              seal_bad,
  input  logic              period_end,
  input  logic [IRQ_W-1:0]  int_mask,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [STAT_W-1:0] wr_data,
  output logic [IRQ_W-1:0]  irq_pending,
  output logic              resched
);
  logic [STAT_W-1:0] status_d, status_q;
  logic              wr_fire;

  ntf_status_reg #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst(rst),
    .done_valid(done_valid), .done_ch(done_ch),
    .err_valid(err_valid), .err_ch(err_ch),
    .wake_valid(wake_valid), .wake_ch(wake_ch),
    .seal_bad(seal_bad),
    .status_d(status_d), .status_q(status_q)
  );

  ntf_change_detect #(.STAT_W(STAT_W)) u_cmp (
    .clk(clk), .rst(rst), .status_d(status_d),
    .period_end(period_end), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_fire(wr_fire)
  );

  ntf_irq_merge #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .int_mask(int_mask),
    .irq_pending(irq_pending), .resched(resched)
  );

  // R9
  wr_data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_data != status_q || $stable(wr_data)));
endmodule

// File: tb/evt_toggle_notifier_tb.sv
module evt_toggle_notifier_tb;
  localparam int SW = 17;
  logic clk = 1'b0, rst = 1'b1;
  logic done_valid = 0, err_valid = 0, wake_valid = 0, seal_bad = 0, period_end = 0;
  logic [1:0] done_ch = 0, err_ch = 0, wake_ch = 0;
  logic [15:0] int_mask = 0;
  logic wr_ready = 0;
  logic wr_valid, resched;
  logic [SW-1:0] wr_data;
  logic [15:0] irq_pending;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  evt_toggle_notifier u_dut (
    .clk(clk), .rst(rst),
    .done_valid(done_valid), .done_ch(done_ch),
    .err_valid(err_valid), .err_ch(err_ch),
    .wake_valid(wake_valid), .wake_ch(wake_ch),
    .seal_bad(seal_bad), .period_end(period_end), .int_mask(int_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .irq_pending(irq_pending), .resched(resched)
  );

  // Behavioural reference model
  logic [SW-1:0] m_st = 0, m_last = 0, m_wd = 0;
  logic [15:0]   m_irq = 0;
  logic          m_wv = 0, m_rs = 0;

  always @(posedge clk) begin
    logic [SW-1:0] ns;
    logic hs;
    if (rst) begin
      m_st = 0; m_last = 0; m_wd = 0; m_irq = 0; m_wv = 0; m_rs = 0;
    end else begin
      ns = m_st;
      if (done_valid) ns = ns ^ (SW'(1) << (3 * done_ch));
      if (err_valid)  ns = ns ^ (SW'(2) << (3 * err_ch));
      if (wake_valid) ns = ns | (SW'(1) << (12 + wake_ch));
      if (seal_bad)   ns = ns | (SW'(1) << 16);
      hs = m_wv && wr_ready;
      m_rs = hs;
      if (hs) begin m_last = m_wd; m_irq = m_irq | int_mask; m_wv = 0; end
      else if (period_end && !m_wv && ns != m_last) begin m_wv = 1; m_wd = ns; end
      m_st = ns;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R6 R7 wr_valid", 32'(wr_valid), 32'(m_wv));
    if (m_wv) chk("R6 R9 wr_data", 32'(wr_data), 32'(m_wd));
    chk("R8 irq_pending", 32'(irq_pending), 32'(m_irq));
    chk("R8 resched", 32'(resched), 32'(m_rs));
  end

  task automatic idle();
    done_valid = 0; err_valid = 0; wake_valid = 0; seal_bad = 0; period_end = 0;
  endtask

  // Strobe, accept the write, return the written word
  task automatic report(output logic [SW-1:0] w);
    period_end = 1; wr_ready = 0;
    @(negedge clk); idle();
    w = wr_data;
    wr_ready = 1;
    @(negedge clk); wr_ready = 0;
  endtask

  initial begin
    logic [SW-1:0] w;
    int_mask = 16'h0005;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 wr_valid", 32'(wr_valid), 0);
    chk("R1 irq", 32'(irq_pending), 0);
    chk("R1 resched", 32'(resched), 0);
    // R6: nothing changed, no write
    period_end = 1; @(negedge clk); idle();
    chk("R6 equal no write", 32'(wr_valid), 0);
    // R2 with same-cycle strobe ordering
    done_valid = 1; done_ch = 2; report(w);
    chk("R2 R6 done ch2 bit6", 32'(w), 32'h40);
    chk("R8 resched", 32'(resched), 1);
    chk("R8 irq", 32'(irq_pending), 32'h5);
    @(negedge clk);
    chk("R8 resched one cycle", 32'(resched), 0);
    // R3 error ch3 plus done ch2 again (cancels)
    err_valid = 1; err_ch = 3; @(negedge clk); idle();
    done_valid = 1; done_ch = 2; int_mask = 16'h0100; report(w);
    chk("R3 err ch3 bit10, R2 cancel", 32'(w), 32'h400);
    chk("R8 irq accum", 32'(irq_pending), 32'h105);
    // R3 cancel: two errors ch3 -> back to equal? status now 0x400 last 0x400; two toggles
    err_valid = 1; err_ch = 3; @(negedge clk);
    @(negedge clk); idle();
    period_end = 1; @(negedge clk); idle();
    chk("R3 double toggle cancels", 32'(wr_valid), 0);
    // R4 R5 sticky
    wake_valid = 1; wake_ch = 1; seal_bad = 1; report(w);
    chk("R4 R5 sticky bits", 32'(w), 32'h12400);
    wake_valid = 1; wake_ch = 1; seal_bad = 1; done_valid = 1; done_ch = 0; report(w);
    chk("R4 R5 stay set", 32'(w), 32'h12401);
    // R7 R9: back-pressure, strobe ignored, later event reported next period
    done_valid = 1; done_ch = 1; period_end = 1; wr_ready = 0;
    @(negedge clk); idle();
    chk("R7 valid", 32'(wr_valid), 1);
    err_valid = 1; err_ch = 0; period_end = 1; @(negedge clk); idle();
    chk("R7 R9 data held", 32'(wr_data), 32'h12409);
    repeat (3) @(negedge clk);
    chk("R7 still held", 32'(wr_valid), 1);
    wr_ready = 1; @(negedge clk); wr_ready = 0;
    chk("R7 strobe dropped", 32'(wr_valid), 0);
    report(w);
    chk("R9 later report", 32'(w), 32'h1240B);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      done_valid = 1'($urandom); done_ch = 2'($urandom);
      err_valid  = 1'($urandom); err_ch  = 2'($urandom);
      wake_valid = ($urandom % 16) == 0; wake_ch = 2'($urandom);
      seal_bad   = ($urandom % 64) == 0;
      period_end = ($urandom % 4) == 0;
      wr_ready   = 1'($urandom);
      int_mask   = 16'(1 << ($urandom % 16));
      @(negedge clk);
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule